// File: doc/BRIEF.md
# Max-Log Trellis State Metric Unit

This block performs one step of the max-log recursion over the 8-state trellis of the LTE turbo constituent code. In each cycle it can take one trellis step. A step carries a systematic soft value, a parity soft value and an a priori value. From these the block forms the four branch metrics, one for each combination of hypothesised input bit and parity bit. It combines them with its stored state metrics and writes back eight normalised, saturated metrics. The branch metrics of the step are registered beside the state metrics, so that a unit placed later in the chain can use them.

A direction input selects forward (alpha) or backward (beta) connectivity, so one datapath serves both recursions of a sliding-window decoder. A window-start pulse loads the initial metrics. In forward mode, and in backward mode when the trellis termination is known, state 0 is favoured. In backward mode at an open window edge, all states start equal. The extrinsic combination and window memory are handled elsewhere.

Top module: `trellis_metric_unit`

## Requirements
- R1: During reset `out_valid` is 0 and the metrics hold the favoured-state-0 pattern: state 0 is 0 and states 1..7 are -2^(MET_W-2).
- R2: For a step, L = sys+apr. Slot 2u+p of `gamma_o` (G_W = IN_W+1 bits per slot, slot 0 at the LSBs) holds the branch metric for input bit u and parity bit p. Slot 3 is floor((L+par)/2) and slot 2 is floor((L-par)/2). Slot 1 is the negation of slot 2, and slot 0 is the negation of slot 3. The slots are registered on the step's clock edge.
- R3: The state index is 4*r1+2*r2+r3, where r1 is the newest register. For input u, the feedback is a = u^r2^r3, the parity is a^r1^r3, and the next state is 4*a+2*r1+r2. In forward mode each new metric is the maximum, over its predecessor states, of the old metric plus the branch metric of that transition.
- R4: In backward mode each new metric of state s is the maximum over u of the old metric of next(s,u) plus the branch metric of that transition.
- R5: After every step the state 0 metric is subtracted from all metrics, so state 0 reads 0.
- R6: After normalisation each metric saturates to the signed MET_W-bit range. State k sits at bits [k*MET_W +: MET_W] of `metrics_o`.
- R7: A window-start pulse in forward mode, or in backward mode with `term_known`=1, loads the favoured-state-0 pattern of R1.
- R8: A window-start pulse in backward mode with `term_known`=0 loads 0 into all eight metrics.
- R9: A window-start pulse takes priority over a step issued in the same cycle. `out_valid` is 1 exactly one cycle after a step that is accepted. Without a step or window start, the metrics hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_valid | input | 1 | Apply one trellis step this cycle |
| win_init | input | 1 | Load the initial metrics for a new window |
| dir_bwd | input | 1 | 0: forward recursion, 1: backward recursion |
| term_known | input | 1 | Backward init uses known termination (state 0 favoured) |
| sys_llr | input | IN_W | Systematic soft value, signed |
| par_llr | input | IN_W | Parity soft value, signed |
| apr_llr | input | IN_W | A priori soft value, signed |
| out_valid | output | 1 | Metrics and branch metrics updated by a step |
| metrics_o | output | 8*MET_W | Eight signed state metrics, state k at bits [k*MET_W +: MET_W] |
| gamma_o | output | 4*(IN_W+1) | Four signed branch metrics, slot 2u+p |

## Verification
The bench builds the block with IN_W=6 and a narrow MET_W=6. With this width the disfavoured value is -16 and the metric range is -32..31, while branch metrics reach ±48. Saturation is therefore reached on the first step after a window start. A full-scale negative input gives an exact saturated pattern. The same table of steps is run in forward mode, in open-edge backward mode and in terminated backward mode. This lets both connectivities and both backward start conditions be compared against a reference model kept in the bench.

// File: rtl/trellis_metric_unit.sv
module trellis_metric_unit #(
  parameter int IN_W  = 6,
  parameter int MET_W = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step_valid,
  input  logic                    win_init,
  input  logic                    dir_bwd,
  input  logic                    term_known,
  input  logic signed [IN_W-1:0]  sys_llr,
  input  logic signed [IN_W-1:0]  par_llr,
  input  logic signed [IN_W-1:0]  apr_llr,
  output logic                    out_valid,
  output logic [8*MET_W-1:0]      metrics_o,
  output logic [4*(IN_W+1)-1:0]   gamma_o
);
  localparam int G_W = IN_W + 1;
  localparam int W2  = MET_W + 3;
  localparam logic signed [MET_W-1:0] DIS  = {2'b11, {(MET_W-2){1'b0}}};
  localparam logic signed [MET_W-1:0] MAXV = {1'b0, {(MET_W-1){1'b1}}};
  localparam logic signed [MET_W-1:0] MINV = {1'b1, {(MET_W-1){1'b0}}};
  localparam logic signed [W2-1:0]    LOWW = {1'b1, {(W2-1){1'b0}}};

  logic signed [MET_W-1:0] m [8];
  logic signed [G_W-1:0]   gq [4];
  logic signed [G_W-1:0]   gam [4];
  logic signed [MET_W-1:0] nxt_m [8];
  logic signed [W2-1:0]    raw [8];

  logic signed [IN_W+1:0] lsum, pext, s_hi, s_lo;
  assign lsum = {{2{sys_llr[IN_W-1]}}, sys_llr} + {{2{apr_llr[IN_W-1]}}, apr_llr};
  assign pext = {{2{par_llr[IN_W-1]}}, par_llr};
  assign s_hi = lsum + pext;
  assign s_lo = lsum - pext;
  assign gam[3] = s_hi[IN_W+1:1];
  assign gam[2] = s_lo[IN_W+1:1];
  assign gam[1] = -gam[2];
  assign gam[0] = -gam[3];

  function automatic logic [2:0] next_st(input logic [2:0] s, input logic u);
    logic a;
    a = u ^ s[1] ^ s[0];
    return {a, s[2], s[1]};
  endfunction

  function automatic logic par_bit(input logic [2:0] s, input logic u);
    return u ^ s[1] ^ s[2];
  endfunction

  always_comb begin
    logic signed [W2-1:0] c, n;
    logic [2:0] s3, t;
    logic u1, pb;
    for (int k = 0; k < 8; k++) raw[k] = LOWW;
    for (int s = 0; s < 8; s++) begin
      for (int u = 0; u < 2; u++) begin
        s3 = 3'(s);
        u1 = (u != 0);
        t  = next_st(s3, u1);
        pb = par_bit(s3, u1);
        if (!dir_bwd) begin
          c = W2'(m[s]) + W2'(gam[{u1, pb}]);
          if (c > raw[t]) raw[t] = c;
        end else begin
          c = W2'(m[t]) + W2'(gam[{u1, pb}]);
          if (c > raw[s]) raw[s] = c;
        end
      end
    end
    for (int k = 0; k < 8; k++) begin
      n = raw[k] - raw[0];
      if (n > W2'(MAXV))      nxt_m[k] = MAXV;
      else if (n < W2'(MINV)) nxt_m[k] = MINV;
      else                    nxt_m[k] = n[MET_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      for (int k = 0; k < 8; k++) m[k] <= (k == 0) ? '0 : DIS;
      for (int j = 0; j < 4; j++) gq[j] <= '0;
    end else begin
      out_valid <= step_valid && !win_init;
      if (win_init) begin
        for (int k = 0; k < 8; k++)
          m[k] <= (dir_bwd && !term_known) ? '0 : ((k == 0) ? '0 : DIS);
      end else if (step_valid) begin
        for (int k = 0; k < 8; k++) m[k] <= nxt_m[k];
        for (int j = 0; j < 4; j++) gq[j] <= gam[j];
      end
    end
  end

  for (genvar k = 0; k < 8; k++) begin : g_pack_m
    assign metrics_o[k*MET_W +: MET_W] = m[k];
  end
  for (genvar j = 0; j < 4; j++) begin : g_pack_g
    assign gamma_o[j*G_W +: G_W] = gq[j];
  end

  assert_norm_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (m[0] == '0));
  assert_init_fav_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_init && !(dir_bwd && !term_known)) |=> (m[0] == '0 && m[1] == DIS && m[4] == DIS && m[7] == DIS));
  assert_init_equal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (win_init && dir_bwd && !term_known) |=> (metrics_o == '0));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_valid && !win_init) |=> ($stable(metrics_o) && !out_valid));
  assert_init_prio_R9: assert property (@(posedge clk) disable iff (!rst_n)
    win_init |=> !out_valid);
endmodule

// File: tb/tb_trellis_metric_unit.sv
module tb_trellis_metric_unit;
  localparam int IW = 6;
  localparam int MW = 6;
  localparam int GW = IW + 1;
  localparam int DISV = -(2 ** (MW - 2));
  localparam int NT = 10;
  localparam int TAB [NT][3] = '{
    '{10, 6, 0}, '{-12, 5, 3}, '{31, -32, 0}, '{-7, -7, -7}, '{0, 0, 0},
    '{20, 11, -15}, '{-32, 31, -32}, '{4, -20, 9}, '{15, 15, 15}, '{-3, 28, -1}};

  logic clk = 0, rst_n = 0, step_valid = 0, win_init = 0, dir_bwd = 0, term_known = 0;
  logic signed [IW-1:0] sys_llr = 0, par_llr = 0, apr_llr = 0;
  logic out_valid;
  logic [8*MW-1:0] metrics_o;
  logic [4*GW-1:0] gamma_o;
  int checks = 0, errors = 0;
  bit done = 0;
  int em [8];
  int eg [4];

  always #10 clk = ~clk;

  trellis_metric_unit #(.IN_W(IW), .MET_W(MW)) dut (
    .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .win_init(win_init),
    .dir_bwd(dir_bwd), .term_known(term_known), .sys_llr(sys_llr),
    .par_llr(par_llr), .apr_llr(apr_llr), .out_valid(out_valid),
    .metrics_o(metrics_o), .gamma_o(gamma_o));

  function automatic int sat(input int v);
    int hi = 2 ** (MW - 1) - 1;
    if (v > hi) return hi;
    if (v < -hi - 1) return -hi - 1;
    return v;
  endfunction

  task automatic model_init(input bit bwd, input bit term);
    for (int k = 0; k < 8; k++) em[k] = (bwd && !term) ? 0 : ((k == 0) ? 0 : DISV);
  endtask

  task automatic model_step(input bit bwd, input int s, input int p, input int a);
    int raw [8];
    int nm [8];
    int L = s + a;
    eg[3] = (L + p) >>> 1;
    eg[2] = (L - p) >>> 1;
    eg[1] = -eg[2];
    eg[0] = -eg[3];
    for (int k = 0; k < 8; k++) raw[k] = -100000;
    for (int st = 0; st < 8; st++) begin
      for (int u = 0; u < 2; u++) begin
        int r1 = (st >> 2) & 1, r2 = (st >> 1) & 1, r3 = st & 1;
        int fb = u ^ r2 ^ r3;
        int pb = fb ^ r1 ^ r3;
        int nx = 4 * fb + 2 * r1 + r2;
        int c;
        if (!bwd) begin
          c = em[st] + eg[2 * u + pb];
          if (c > raw[nx]) raw[nx] = c;
        end else begin
          c = em[nx] + eg[2 * u + pb];
          if (c > raw[st]) raw[st] = c;
        end
      end
    end
    for (int k = 0; k < 8; k++) nm[k] = sat(raw[k] - raw[0]);
    for (int k = 0; k < 8; k++) em[k] = nm[k];
  endtask

  function automatic int got_m(input int k);
    return int'($signed(metrics_o[k*MW +: MW]));
  endfunction
  function automatic int got_g(input int j);
    return int'($signed(gamma_o[j*GW +: GW]));
  endfunction

  task automatic chk_metrics(input string rq);
    bit bad = 0;
    checks++;
    for (int k = 0; k < 8; k++) if (got_m(k) != em[k]) bad = 1;
    if (bad) begin
      errors++;
      $display("FAIL %s metrics got %0d %0d %0d %0d %0d %0d %0d %0d exp %0d %0d %0d %0d %0d %0d %0d %0d", rq,
        got_m(0), got_m(1), got_m(2), got_m(3), got_m(4), got_m(5), got_m(6), got_m(7),
        em[0], em[1], em[2], em[3], em[4], em[5], em[6], em[7]);
    end
  endtask

  task automatic chk_gamma(input string rq);
    bit bad = 0;
    checks++;
    for (int j = 0; j < 4; j++) if (got_g(j) != eg[j]) bad = 1;
    if (bad) begin
      errors++;
      $display("FAIL %s gamma got %0d %0d %0d %0d exp %0d %0d %0d %0d", rq,
        got_g(0), got_g(1), got_g(2), got_g(3), eg[0], eg[1], eg[2], eg[3]);
    end
  endtask

  task automatic chk_bit(input string rq, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s out_valid got %0b exp %0b", rq, got, exp);
    end
  endtask

  task automatic do_init(input bit bwd, input bit term);
    dir_bwd = bwd; term_known = term; win_init = 1;
    @(negedge clk);
    win_init = 0;
    model_init(bwd, term);
  endtask

  task automatic do_step(input bit bwd, input int s, input int p, input int a);
    dir_bwd = bwd; sys_llr = IW'(s); par_llr = IW'(p); apr_llr = IW'(a); step_valid = 1;
    @(negedge clk);
    step_valid = 0;
    model_step(bwd, s, p, a);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    model_init(0, 0);
    chk_metrics("R1 reset");
    chk_bit("R1 reset", out_valid, 1'b0);
    rst_n = 1;
    @(negedge clk);

    // R3 R2 R5 R6: forward walk
    do_init(0, 0);
    chk_metrics("R7 fwd init");
    for (int i = 0; i < NT; i++) begin
      do_step(0, TAB[i][0], TAB[i][1], TAB[i][2]);
      chk_metrics("R3 fwd step");
      chk_gamma("R2 fwd gamma");
      chk_bit("R9 valid after step", out_valid, 1'b1);
    end

    // R4 R8: backward open edge, table reversed
    do_init(1, 0);
    chk_metrics("R8 bwd open init");
    for (int i = NT - 1; i >= 0; i--) begin
      do_step(1, TAB[i][0], TAB[i][1], TAB[i][2]);
      chk_metrics("R4 bwd step");
      chk_gamma("R2 bwd gamma");
    end

    // R7 backward terminated
    do_init(1, 1);
    chk_metrics("R7 bwd term init");
    for (int i = 0; i < 4; i++) begin
      do_step(1, TAB[i][0], TAB[i][1], TAB[i][2]);
      chk_metrics("R4 bwd term step");
    end

    // R3 hand value: sys=10 par=6 apr=0 from forward start, state4=16
    do_init(0, 0);
    do_step(0, 10, 6, 0);
    checks++;
    if (got_m(4) != 16 || got_m(0) != 0) begin
      errors++;
      $display("FAIL R3 hand state4 got %0d exp 16 state0 got %0d exp 0", got_m(4), got_m(0));
    end
    checks++;
    if (got_g(3) != 8 || got_g(2) != 2 || got_g(1) != -2 || got_g(0) != -8) begin
      errors++;
      $display("FAIL R2 hand gamma got %0d %0d %0d %0d exp -8 -2 2 8", got_g(0), got_g(1), got_g(2), got_g(3));
    end

    // R6 saturation: full-scale negative inputs, exact expected pattern
    do_init(0, 0);
    do_step(0, -32, -32, -32);
    em = '{0, -32, -32, -16, -16, -32, -32, -16};
    chk_metrics("R6 saturation");
    chk_metrics("R5 state0 zero");

    // R9 hold: idle cycle keeps metrics, out_valid drops
    @(negedge clk);
    chk_metrics("R9 hold");
    chk_bit("R9 idle valid", out_valid, 1'b0);

    // R9 priority: init and step together
    dir_bwd = 0; term_known = 0; win_init = 1; step_valid = 1;
    sys_llr = 6'sd20; par_llr = 6'sd5; apr_llr = 6'sd3;
    @(negedge clk);
    win_init = 0; step_valid = 0;
    model_init(0, 0);
    chk_metrics("R9 init priority");
    chk_bit("R9 init priority valid", out_valid, 1'b0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired got running exp done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule